// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write single bits in an external clockless static RAM. The RAM has 16384 one-bit locations, a 14-bit address, a dedicated data-in pin and a dedicated data-out pin. It is steered only by two active-low strobes, chip enable and write enable. On the user side a request carrying address, direction and write bit is taken whenever `ready_o` is high. A read returns its bit with a one-cycle valid pulse.

All RAM timing minimums are parameters in nanoseconds, together with the clock period. At elaboration each minimum becomes a cycle count: divide by the period, round up, and never go below one cycle. Every strobe edge is then placed on a fixed clock edge, counted from the edge that accepted the request. A parameter selects one of two write styles. In the first, the write-enable pulse inside an enabled cycle ends the write. In the second, the chip-enable pulse inside a write-enable window ends it.

Top module: `async_sram_seq`

## Requirements
- R1: While and after reset, `sram_ce_n_o` and `sram_we_n_o` are 1, `ready_o` is 1 and `rd_valid_o` is 0.
- R2: A request is taken only on a clock edge where `req_i` and `ready_o` are both 1. `ready_o` is 0 from the next cycle on. A request raised while `ready_o` is 0 has no effect on the pins or on the RAM contents.
- R3: Each phase length is max(1, ceil(ns / CLK_PERIOD_NS)). `ready_o` returns to 1 exactly D edges after the accepting edge E0. D is the larger of the cycle-time count and the edge where the access's last strobe rises. With the defaults, D = 11 for every access.
- R4: A read drives `sram_ce_n_o` low from E0. At edge E_A (A = access-time count, 11 by default) it registers `sram_dout_i` and raises `sram_ce_n_o`. It pulses `rd_valid_o` for exactly one cycle after that edge, with `rd_data_o` holding the sampled bit. A write never pulses `rd_valid_o`.
- R5: In the write-enable style (WRITE_STYLE = 0), a write drives `sram_ce_n_o` low at E0 and `sram_we_n_o` low at E1. It raises `sram_we_n_o` at E_T, where T = max(address-to-end count, data-setup count, 1 + write-pulse count), which is 9 by default. It raises `sram_ce_n_o` at E_{T+1}.
- R6: In the chip-enable style (WRITE_STYLE = 1), a write drives `sram_we_n_o` low at E0 and `sram_ce_n_o` low at E1. It raises `sram_ce_n_o` at E_T, where T = max(address-to-end count, data-setup count, 1 + enable-pulse count), which is 10 by default. It raises `sram_we_n_o` at E_{T+1}.
- R7: In the write-enable style, `sram_we_n_o` is low only while `sram_ce_n_o` is low. In the chip-enable style, during a write `sram_ce_n_o` is low only while `sram_we_n_o` is low.
- R8: `sram_addr_o` and `sram_din_o` change only on an accepting edge. They stay fixed until the next accepted request.
- R9: Any of the 16384 addresses, including 0 and 16383, reads back the bit last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, taken when ready_o is 1 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Bit address |
| req_wdata_i | input | 1 | Bit to write |
| ready_o | output | 1 | Able to accept a request |
| rd_valid_o | output | 1 | One-cycle pulse, read data valid |
| rd_data_o | output | 1 | Read bit |
| sram_addr_o | output | ADDR_W | RAM address pins |
| sram_din_o | output | 1 | RAM data-in pin |
| sram_dout_i | input | 1 | RAM data-out pin |
| sram_ce_n_o | output | 1 | RAM chip enable, active low |
| sram_we_n_o | output | 1 | RAM write enable, active low |

## Verification
The assertions rely on one input rule: a requester offers a request only as a single-cycle `req_i` pulse. They assume nothing about the data returned on `sram_dout_i`. The bench follows that rule and goes further: it raises `req_i` only after seeing `ready_o` high, except in the deliberate busy-time intrusion that tests R2. The bench's RAM model treats its output as valid only once both the address and the enable have been stable for the access time, measured in real nanoseconds. Before that it returns the inverted bit, so a sample taken too early shows up as a data mismatch. The model also checks, in nanoseconds, the write pulse, the address-to-end time, the data setup, the enable pulse and the spacing between cycles.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [0:0] {
    WSTYLE_WE = 1'b0,
    WSTYLE_CE = 1'b1
  } wstyle_e;

  typedef enum logic [0:0] {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_elapsed.sv
module sram_seq_elapsed #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned K_MAX = 11
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             busy_i,
  output logic [CNT_W-1:0] el_o,
  output logic [CNT_W-1:0] nxt_o
);

  localparam logic [CNT_W-1:0] KW_MAX = CNT_W'(K_MAX);

  // el_o = number of edges since the accepting edge
  always_ff @(posedge clk_i) begin
    if (rst_i)        el_o <= '0;
    else if (start_i) el_o <= '0;
    else if (busy_i)  el_o <= el_o + 1'b1;
  end

  assign nxt_o = el_o + 1'b1;

  // R3: an access never runs past its longest schedule
  a_r3_count_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i |-> (el_o < KW_MAX));

endmodule

// File: rtl/sram_seq_sched.sv
module sram_seq_sched
  import sram_seq_pkg::*;
#(
  parameter wstyle_e     WRITE_STYLE = WSTYLE_WE,
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned K_SAMPLE    = 11,
  parameter int unsigned K_RD_DONE   = 11,
  parameter int unsigned K_TERM      = 9,
  parameter int unsigned K_WR_DONE   = 11
) (
  input  logic             act_i,
  input  op_e              op_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic             ev_ce_fall_o,
  output logic             ev_ce_rise_o,
  output logic             ev_we_fall_o,
  output logic             ev_we_rise_o,
  output logic             ev_sample_o,
  output logic             ev_done_o
);

  localparam logic [CNT_W-1:0] KW_ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] KW_SAMPLE  = CNT_W'(K_SAMPLE);
  localparam logic [CNT_W-1:0] KW_RD_DONE = CNT_W'(K_RD_DONE);
  localparam logic [CNT_W-1:0] KW_TERM    = CNT_W'(K_TERM);
  localparam logic [CNT_W-1:0] KW_REL     = CNT_W'(K_TERM + 1);
  localparam logic [CNT_W-1:0] KW_WR_DONE = CNT_W'(K_WR_DONE);

  logic rd, wr;
  assign rd = act_i && (op_i == OP_RD);
  assign wr = act_i && (op_i == OP_WR);

  assign ev_sample_o = rd && (nxt_i == KW_SAMPLE);
  assign ev_done_o   = (rd && (nxt_i == KW_RD_DONE)) || (wr && (nxt_i == KW_WR_DONE));

  generate
    if (WRITE_STYLE == WSTYLE_WE) begin : g_we_term
      // enable opens at E0, write strobe sits inside it
      assign ev_we_fall_o = wr && (nxt_i == KW_ONE);
      assign ev_we_rise_o = wr && (nxt_i == KW_TERM);
      assign ev_ce_fall_o = 1'b0;
      assign ev_ce_rise_o = ev_sample_o || (wr && (nxt_i == KW_REL));
    end else begin : g_ce_term
      // write strobe opens at E0, enable pulse sits inside it
      assign ev_ce_fall_o = wr && (nxt_i == KW_ONE);
      assign ev_ce_rise_o = ev_sample_o || (wr && (nxt_i == KW_TERM));
      assign ev_we_fall_o = 1'b0;
      assign ev_we_rise_o = wr && (nxt_i == KW_REL);
    end
  endgenerate

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter wstyle_e     WRITE_STYLE = WSTYLE_WE,
  parameter int unsigned ADDR_W      = 14
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  op_e               start_op_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              start_din_i,
  input  logic              ev_ce_fall_i,
  input  logic              ev_ce_rise_i,
  input  logic              ev_we_fall_i,
  input  logic              ev_we_rise_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              din_o,
  output logic              ce_n_o,
  output logic              we_n_o
);

  logic we_first;
  assign we_first = (WRITE_STYLE == WSTYLE_CE) && (start_op_i == OP_WR);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_o <= '0;
      din_o  <= 1'b0;
      ce_n_o <= 1'b1;
      we_n_o <= 1'b1;
    end else if (start_i) begin
      addr_o <= start_addr_i;
      din_o  <= start_din_i;
      ce_n_o <= we_first;
      we_n_o <= !we_first;
    end else begin
      if (ev_ce_fall_i) ce_n_o <= 1'b0;
      if (ev_ce_rise_i) ce_n_o <= 1'b1;
      if (ev_we_fall_i) we_n_o <= 1'b0;
      if (ev_we_rise_i) we_n_o <= 1'b1;
    end
  end

endmodule

// File: rtl/async_sram_seq.sv
module async_sram_seq
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W          = 14,
  parameter int unsigned CLK_PERIOD_NS   = 8,
  parameter int unsigned T_CYCLE_NS      = 85,
  parameter int unsigned T_ACCESS_NS     = 85,
  parameter int unsigned T_WE_PULSE_NS   = 45,
  parameter int unsigned T_ADDR_WEND_NS  = 65,
  parameter int unsigned T_DATA_SETUP_NS = 35,
  parameter int unsigned T_CE_PULSE_NS   = 65,
  parameter wstyle_e     WRITE_STYLE     = WSTYLE_WE
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wdata_i,
  output logic              ready_o,
  output logic              rd_valid_o,
  output logic              rd_data_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_din_o,
  input  logic              sram_dout_i,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o
);

  // Nanosecond minimums turned into cycle counts
  localparam int unsigned C_CYC = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_ACC = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WP  = ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_AW  = ns_to_cyc(T_ADDR_WEND_NS, CLK_PERIOD_NS);
  localparam int unsigned C_DS  = ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned C_CEP = ns_to_cyc(T_CE_PULSE_NS, CLK_PERIOD_NS);

  // Edge indices counted from the accepting edge
  localparam int unsigned K_SAMPLE  = C_ACC;
  localparam int unsigned K_RD_DONE = max2(C_CYC, C_ACC);
  localparam int unsigned K_PULSE   = (WRITE_STYLE == WSTYLE_WE) ? C_WP : C_CEP;
  localparam int unsigned K_TERM    = max2(max2(C_AW, C_DS), 1 + K_PULSE);
  localparam int unsigned K_WR_DONE = max2(C_CYC, K_TERM + 1);
  localparam int unsigned K_MAX     = max2(K_RD_DONE, K_WR_DONE);
  localparam int unsigned CNT_W     = $clog2(K_MAX + 1) + 1;

  localparam logic [CNT_W-1:0] KW_RD_DONE = CNT_W'(K_RD_DONE);
  localparam logic [CNT_W-1:0] KW_WR_DONE = CNT_W'(K_WR_DONE);

  logic             busy_q;
  logic             ready_q;
  op_e              op_q;
  logic             accept;
  logic [CNT_W-1:0] el_w, nxt_w;
  logic             ev_ce_fall, ev_ce_rise, ev_we_fall, ev_we_rise, ev_sample, ev_done;
  logic             rv_q, rd_q;

  assign accept = req_i && ready_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
      op_q    <= OP_RD;
    end else if (accept) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
      op_q    <= req_write_i ? OP_WR : OP_RD;
    end else if (busy_q && ev_done) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rv_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      rv_q <= ev_sample;
      if (ev_sample) rd_q <= sram_dout_i;
    end
  end

  assign ready_o    = ready_q;
  assign rd_valid_o = rv_q;
  assign rd_data_o  = rd_q;

  sram_seq_elapsed #(
    .CNT_W (CNT_W),
    .K_MAX (K_MAX)
  ) elapsed_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (accept),
    .busy_i  (busy_q),
    .el_o    (el_w),
    .nxt_o   (nxt_w)
  );

  sram_seq_sched #(
    .WRITE_STYLE (WRITE_STYLE),
    .CNT_W       (CNT_W),
    .K_SAMPLE    (K_SAMPLE),
    .K_RD_DONE   (K_RD_DONE),
    .K_TERM      (K_TERM),
    .K_WR_DONE   (K_WR_DONE)
  ) sched_i (
    .act_i        (busy_q),
    .op_i         (op_q),
    .nxt_i        (nxt_w),
    .ev_ce_fall_o (ev_ce_fall),
    .ev_ce_rise_o (ev_ce_rise),
    .ev_we_fall_o (ev_we_fall),
    .ev_we_rise_o (ev_we_rise),
    .ev_sample_o  (ev_sample),
    .ev_done_o    (ev_done)
  );

  sram_seq_pins #(
    .WRITE_STYLE (WRITE_STYLE),
    .ADDR_W      (ADDR_W)
  ) pins_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .start_i      (accept),
    .start_op_i   (req_write_i ? OP_WR : OP_RD),
    .start_addr_i (req_addr_i),
    .start_din_i  (req_wdata_i),
    .ev_ce_fall_i (ev_ce_fall),
    .ev_ce_rise_i (ev_ce_rise),
    .ev_we_fall_i (ev_we_fall),
    .ev_we_rise_i (ev_we_rise),
    .addr_o       (sram_addr_o),
    .din_o        (sram_din_o),
    .ce_n_o       (sram_ce_n_o),
    .we_n_o       (sram_we_n_o)
  );

  // R1: strobes released whenever no access is in flight
  a_r1_idle_strobes: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |-> (sram_ce_n_o && sram_we_n_o));

  // R2: an accepted request drops ready on the next cycle
  a_r2_accept_drops_ready: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && ready_o) |=> !ready_o);

  // R3: ready returns exactly on the scheduled edge count
  a_r3_ready_on_time: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_o) |-> (el_w == ((op_q == OP_RD) ? KW_RD_DONE : KW_WR_DONE)));

  // R4: valid pulse lasts one cycle and coincides with the enable release
  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid_o |=> !rd_valid_o);
  a_r4_valid_with_release: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid_o |-> $rose(sram_ce_n_o));

  // R8: pins frozen while an access runs
  a_r8_pins_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    !ready_o |=> ($stable(sram_addr_o) && $stable(sram_din_o)));

  // R7: strobe nesting per write style
  generate
    if (WRITE_STYLE == WSTYLE_WE) begin : g_chk_we
      a_r7_we_inside_ce: assert property (@(posedge clk_i) disable iff (rst_i)
        !sram_we_n_o |-> !sram_ce_n_o);
    end else begin : g_chk_ce
      a_r7_ce_inside_we: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sram_ce_n_o && (op_q == OP_WR)) |-> !sram_we_n_o);
    end
  endgenerate

endmodule

// File: tb/async_sram_seq_tb_top.sv
module sram_model_tb #(
  parameter bit  CE_STYLE = 1'b0,
  parameter real ACC_NS   = 85.0,
  parameter real CYC_NS   = 85.0,
  parameter real WP_NS    = 45.0,
  parameter real AW_NS    = 65.0,
  parameter real DS_NS    = 35.0,
  parameter real CEP_NS   = 65.0
) (
  input  logic [13:0] addr,
  input  logic        din,
  input  logic        ce_n,
  input  logic        we_n,
  output logic        dout,
  output int          n_chk,
  output int          n_err
);
  timeunit 1ns;
  timeprecision 100ps;

  bit  mem [16384];
  real t_addr = -1000.0;
  real t_din  = -1000.0;
  real t_ce   = -1000.0;
  real t_we   = -1000.0;

  function automatic bit pat(input int a);
    return bit'(((a >> 0) ^ (a >> 3) ^ (a >> 7) ^ (a >> 13)) & 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0.1f ns, expected >= %0.1f ns", req, what, act, exp);
    end
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    for (int i = 0; i < 16384; i++) mem[i] = pat(i);
    dout = 1'b0;
    #0.5;
    forever begin
      if (!ce_n && we_n && ($realtime - t_addr >= ACC_NS) && ($realtime - t_ce >= ACC_NS))
        dout = mem[addr];
      else
        dout = !mem[addr];
      #1;
    end
  end

  always @(addr) t_addr = $realtime;
  always @(din)  t_din  = $realtime;

  always @(negedge ce_n) begin
    chk($realtime - t_ce >= CYC_NS, "R3", "cycle spacing", $realtime - t_ce, CYC_NS);
    t_ce = $realtime;
  end

  always @(negedge we_n) t_we = $realtime;

  always @(posedge we_n) begin
    if (!ce_n) begin
      chk(!CE_STYLE, "R6", "write ended by write strobe", 0.0, 1.0);
      chk($realtime - t_we >= WP_NS, "R5", "write pulse", $realtime - t_we, WP_NS);
      chk($realtime - t_addr >= AW_NS, "R5", "address to end", $realtime - t_addr, AW_NS);
      chk($realtime - t_din >= DS_NS, "R5", "data setup", $realtime - t_din, DS_NS);
      mem[addr] = din;
    end
  end

  always @(posedge ce_n) begin
    if (!we_n) begin
      chk(CE_STYLE, "R5", "write ended by enable", 0.0, 1.0);
      chk($realtime - t_ce >= CEP_NS, "R6", "enable pulse", $realtime - t_ce, CEP_NS);
      chk($realtime - t_addr >= AW_NS, "R6", "address to end", $realtime - t_addr, AW_NS);
      chk($realtime - t_din >= DS_NS, "R6", "data setup", $realtime - t_din, DS_NS);
      mem[addr] = din;
    end
  end
endmodule

module async_sram_seq_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PER = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req [2];
  logic        wr  [2];
  logic [13:0] ad  [2];
  logic        wd  [2];
  logic        rdy [2];
  logic        rv  [2];
  logic        rd  [2];
  logic [13:0] sa  [2];
  logic        sd  [2];
  logic        sq  [2];
  logic        ce_n[2];
  logic        we_n[2];
  int          m_chk[2];
  int          m_err[2];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  exp_mem [2][16384];

  async_sram_seq #(.WRITE_STYLE(sram_seq_pkg::WSTYLE_WE)) dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req[0]), .req_write_i(wr[0]), .req_addr_i(ad[0]),
    .req_wdata_i(wd[0]), .ready_o(rdy[0]), .rd_valid_o(rv[0]), .rd_data_o(rd[0]),
    .sram_addr_o(sa[0]), .sram_din_o(sd[0]), .sram_dout_i(sq[0]),
    .sram_ce_n_o(ce_n[0]), .sram_we_n_o(we_n[0]));

  async_sram_seq #(.WRITE_STYLE(sram_seq_pkg::WSTYLE_CE)) dut_ce_i (
    .clk_i(clk), .rst_i(rst), .req_i(req[1]), .req_write_i(wr[1]), .req_addr_i(ad[1]),
    .req_wdata_i(wd[1]), .ready_o(rdy[1]), .rd_valid_o(rv[1]), .rd_data_o(rd[1]),
    .sram_addr_o(sa[1]), .sram_din_o(sd[1]), .sram_dout_i(sq[1]),
    .sram_ce_n_o(ce_n[1]), .sram_we_n_o(we_n[1]));

  sram_model_tb #(.CE_STYLE(1'b0)) ram_we_i (
    .addr(sa[0]), .din(sd[0]), .ce_n(ce_n[0]), .we_n(we_n[0]), .dout(sq[0]),
    .n_chk(m_chk[0]), .n_err(m_err[0]));
  sram_model_tb #(.CE_STYLE(1'b1)) ram_ce_i (
    .addr(sa[1]), .din(sd[1]), .ce_n(ce_n[1]), .we_n(we_n[1]), .dout(sq[1]),
    .n_chk(m_chk[1]), .n_err(m_err[1]));

  function automatic int cyc(input int ns);
    int c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic bit pat(input int a);
    return bit'(((a >> 0) ^ (a >> 3) ^ (a >> 7) ^ (a >> 13)) & 1);
  endfunction
  // Write termination edge per style (R5, R6)
  function automatic int k_term(input int d);
    return mx(mx(cyc(65), cyc(35)), 1 + ((d == 0) ? cyc(45) : cyc(65)));
  endfunction
  // Ready return edge (R3)
  function automatic int k_done(input int d, input bit w);
    return w ? mx(cyc(85), k_term(d) + 1) : mx(cyc(85), cyc(85));
  endfunction

  task automatic check(input bit ok, input string req_tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (style %0d)", req_tag, what, act, exp, 0);
    end
  endtask

  // One access on port d; optional intrusion while busy targets addr ia.
  task automatic do_op(input int d, input bit w, input logic [13:0] a, input bit v,
                       input bit intrude, input logic [13:0] ia);
    int  k_valid = -1, k_ready = -1, k_ce_rise = -1, k_we_rise = -1, k_we_fall = -1, k_ce_fall = -1;
    int  pulses = 0;
    bit  got = 1'b0, pins_ok = 1'b1, prev_ce, prev_we;
    @(negedge clk);
    req[d] = 1'b1; wr[d] = w; ad[d] = a; wd[d] = v;
    @(posedge clk);
    @(negedge clk);
    req[d] = 1'b0;
    prev_ce = ce_n[d];
    prev_we = we_n[d];
    if (w && d == 1) begin
      check(!we_n[d] && ce_n[d], "R6", "strobes after E0 (we_n,ce_n)", {we_n[d], ce_n[d]}, 1);
    end else begin
      check(!ce_n[d] && we_n[d], "R4", "strobes after E0 (ce_n,we_n)", {ce_n[d], we_n[d]}, 1);
    end
    for (int k = 1; k <= 40; k++) begin
      if (intrude && k == 3) begin
        req[d] = 1'b1; wr[d] = 1'b1; ad[d] = ia; wd[d] = !exp_mem[d][ia];
      end
      if (intrude && k == 4) req[d] = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (sa[d] != a || sd[d] != v) pins_ok = 1'b0;
      if (rv[d]) begin pulses++; if (k_valid < 0) begin k_valid = k; got = rd[d]; end end
      if (ce_n[d] && !prev_ce && k_ce_rise < 0) k_ce_rise = k;
      if (!ce_n[d] && prev_ce && k_ce_fall < 0) k_ce_fall = k;
      if (we_n[d] && !prev_we && k_we_rise < 0) k_we_rise = k;
      if (!we_n[d] && prev_we && k_we_fall < 0) k_we_fall = k;
      prev_ce = ce_n[d];
      prev_we = we_n[d];
      if (rdy[d]) begin k_ready = k; break; end
    end
    check(k_ready == k_done(d, w), "R3", "ready return edge", k_ready, k_done(d, w));
    check(pins_ok, "R8", "address/data held", 0, 1);
    if (!w) begin
      check(k_valid == cyc(85), "R4", "read valid edge", k_valid, cyc(85));
      check(pulses == 1, "R4", "valid pulse count", pulses, 1);
      check(k_ce_rise == cyc(85), "R4", "enable release edge", k_ce_rise, cyc(85));
      check(got == exp_mem[d][a], "R9", "read data", got, exp_mem[d][a]);
    end else begin
      check(pulses == 0, "R4", "no valid on write", pulses, 0);
      if (d == 0) begin
        check(k_we_fall == 1, "R5", "write strobe fall edge", k_we_fall, 1);
        check(k_we_rise == k_term(0), "R5", "write strobe rise edge", k_we_rise, k_term(0));
        check(k_ce_rise == k_term(0) + 1, "R5", "enable rise edge", k_ce_rise, k_term(0) + 1);
      end else begin
        check(k_ce_fall == 1, "R6", "enable fall edge", k_ce_fall, 1);
        check(k_ce_rise == k_term(1), "R6", "enable rise edge", k_ce_rise, k_term(1));
        check(k_we_rise == k_term(1) + 1, "R6", "write strobe rise edge", k_we_rise, k_term(1) + 1);
      end
      exp_mem[d][a] = v;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      for (int d = 0; d < 2; d++) begin
        checks += m_chk[d];
        errors += m_err[d];
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PER * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 2; d++) begin
      req[d] = 1'b0; wr[d] = 1'b0; ad[d] = '0; wd[d] = 1'b0;
      for (int i = 0; i < 16384; i++) exp_mem[d][i] = pat(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    for (int d = 0; d < 2; d++)
      check(ce_n[d] && we_n[d] && rdy[d] && !rv[d], "R1", "reset outputs",
            {ce_n[d], we_n[d], rdy[d], rv[d]}, 4'b1110);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 2; d++)
      check(ce_n[d] && we_n[d] && rdy[d] && !rv[d], "R1", "after reset outputs",
            {ce_n[d], we_n[d], rdy[d], rv[d]}, 4'b1110);

    for (int d = 0; d < 2; d++) begin
      // R9: extreme addresses, both values
      do_op(d, 1'b0, 14'd0, 1'b0, 1'b0, 14'd0);
      do_op(d, 1'b1, 14'd0, !exp_mem[d][0], 1'b0, 14'd0);
      do_op(d, 1'b0, 14'd0, 1'b0, 1'b0, 14'd0);
      do_op(d, 1'b1, 14'h3FFF, !exp_mem[d][16383], 1'b0, 14'd0);
      do_op(d, 1'b0, 14'h3FFF, 1'b0, 1'b0, 14'd0);
      // R2: request during busy is ignored
      do_op(d, 1'b1, 14'd100, 1'b1, 1'b1, 14'd200);
      do_op(d, 1'b0, 14'd200, 1'b0, 1'b0, 14'd0);
      do_op(d, 1'b0, 14'd100, 1'b0, 1'b0, 14'd0);
      // Random mix over a small and the full address range
      for (int n = 0; n < 250; n++) begin
        logic [13:0] ra;
        ra = ($urandom_range(0, 3) == 0) ? 14'($urandom_range(0, 16383)) : 14'($urandom_range(0, 31));
        do_op(d, 1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)), 1'b0, 14'd0);
      end
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule